// File: doc/BRIEF.md
# Programmable AND / Fixed OR Logic Array

This block is a small sum-of-products core of the programmable-array-logic kind. Four primary inputs each enter an AND plane twice, once as the true signal and once inverted, so the plane holds eight literals. Thirteen product terms each pick any subset of these literals through configuration bits. The terms are wired in fixed, exclusive groups to five OR gates. The group sizes are uneven, 2, 3, 3, 3 and 2 terms in output order. A term that belongs to one output can never add to another, unlike an array in which the OR plane is programmable too.

The configuration is a static parallel vector that the surrounding logic holds steady. Each term carries one enable bit besides its literal mask, so an unused term is held at 0 and does not disturb its OR gate. The block has no clock and no state. Every output is a pure combinational function of the inputs and the configuration.

Top module: `pal_core`

## Requirements
- R1: Literal 2i of the AND plane is input bit i and literal 2i+1 is its complement, for i in 0..3.
- R2: Term t (0..12) uses mask bits cfg[8t+7:8t]. Mask bit k set means literal k is in the product, and an enabled term is the AND of its selected literals.
- R3: An enabled term with an all-zero literal mask evaluates to 1.
- R4: An enabled term that selects both literal 2i and literal 2i+1 evaluates to 0 for every input value.
- R5: Bit cfg[104+t] enables term t. When it is 0 the term is 0 whatever its mask selects.
- R6: The groups are fixed. Terms 0-1 feed out_vec[0], terms 2-4 feed out_vec[1], terms 5-7 feed out_vec[2], terms 8-10 feed out_vec[3] and terms 11-12 feed out_vec[4].
- R7: Each output is the OR of its own group's terms only. A term never changes any other output, and an output whose group is fully disabled is 0.
- R8: The outputs follow in_vec and cfg combinationally, with no clock and no stored state. The all-zero configuration gives all outputs 0 for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_vec | input | 4 | Primary logic inputs |
| cfg | input | 117 | Literal masks, 8 bits per term for terms 0..12 from bit 0 upward, then 13 term enable bits from bit 104 upward |
| out_vec | output | 5 | Sum-of-products outputs, bit o is OR gate o |

## Verification
No register lies between any input and any output. Every result is therefore due in the same time step as the stimulus that causes it, zero cycles later. The bench changes in_vec and cfg just after a falling clock edge and reads out_vec a quarter period later, well before the next rising edge. Each reading thus reflects only the stimulus just applied and never one that arrives later.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Number of product terms wired to OR gate o. The two end gates take
  // edge_terms, the gates in between take mid_terms.
  function automatic int grp_terms(input int o, input int n_out,
                                   input int edge_terms, input int mid_terms);
    if (o == 0 || o == n_out - 1) return edge_terms;
    return mid_terms;
  endfunction

  // Index of the first product term owned by OR gate o.
  function automatic int grp_base(input int o, input int n_out,
                                  input int edge_terms, input int mid_terms);
    int acc;
    acc = 0;
    for (int k = 0; k < o; k++) acc += grp_terms(k, n_out, edge_terms, mid_terms);
    return acc;
  endfunction

  // Total product terms in the array.
  function automatic int total_terms(input int n_out,
                                     input int edge_terms, input int mid_terms);
    return grp_base(n_out, n_out, edge_terms, mid_terms);
  endfunction

endpackage

// File: rtl/pal_literal_gen.sv
module pal_literal_gen #(
  parameter int N_IN = 4,
  localparam int N_LIT = 2 * N_IN
) (
  input  logic [N_IN-1:0]  in_vec,
  output logic [N_LIT-1:0] lits
);

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lits[2*i]   = in_vec[i];
    assign lits[2*i+1] = ~in_vec[i];

    always_comb begin
      if (!$isunknown(in_vec[i])) begin
        assert_true_literal_R1: assert (lits[2*i] == in_vec[i])
          else $error("literal %0d is not the true input", 2*i);
        assert_pair_opposite_R1: assert (lits[2*i] != lits[2*i+1])
          else $error("literal pair %0d not complementary", i);
      end
    end
  end

endmodule

// File: rtl/pal_and_term.sv
module pal_and_term #(
  parameter int N_LIT = 8
) (
  input  logic [N_LIT-1:0] lits,
  input  logic [N_LIT-1:0] mask,
  input  logic             en,
  output logic             term
);

  localparam int N_PAIR = N_LIT / 2;

  // A literal left out of the mask reads as 1, so the AND reduces over
  // the selected literals only.
  logic [N_LIT-1:0] gated;
  assign gated = lits | ~mask;
  assign term  = en & (&gated);

  logic [N_PAIR-1:0] pair_both;
  always_comb begin
    for (int i = 0; i < N_PAIR; i++) pair_both[i] = mask[2*i] & mask[2*i+1];
  end

  always_comb begin
    if (!$isunknown({lits, mask, en})) begin
      if (!en) begin
        assert_disabled_low_R5: assert (term == 1'b0)
          else $error("disabled term is high");
      end
      if (en && mask == '0) begin
        assert_empty_high_R3: assert (term == 1'b1)
          else $error("empty enabled term is low");
      end
      if (en && pair_both != '0) begin
        assert_contradiction_low_R4: assert (term == 1'b0)
          else $error("contradictory term is high");
      end
    end
  end

endmodule

// File: rtl/pal_or_group.sv
module pal_or_group #(
  parameter int N_T = 2
) (
  input  logic [N_T-1:0] terms,
  output logic           y
);

  assign y = |terms;

endmodule

// File: rtl/pal_core.sv
module pal_core
  import pal_pkg::*;
#(
  parameter int N_IN       = 4,
  parameter int N_OUT      = 5,
  parameter int EDGE_TERMS = 2,
  parameter int MID_TERMS  = 3,
  localparam int N_LIT  = 2 * N_IN,
  localparam int N_TERM = total_terms(N_OUT, EDGE_TERMS, MID_TERMS),
  localparam int CFG_W  = N_TERM * (N_LIT + 1)
) (
  input  logic [N_IN-1:0]  in_vec,
  input  logic [CFG_W-1:0] cfg,
  output logic [N_OUT-1:0] out_vec
);

  localparam int EN_BASE = N_TERM * N_LIT;

  logic [N_LIT-1:0]  lits;
  logic [N_TERM-1:0] prod;

  pal_literal_gen #(.N_IN(N_IN)) lit_i (
    .in_vec (in_vec),
    .lits   (lits)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    localparam int BASE = grp_base(o, N_OUT, EDGE_TERMS, MID_TERMS);
    localparam int NT   = grp_terms(o, N_OUT, EDGE_TERMS, MID_TERMS);

    for (genvar k = 0; k < NT; k++) begin : g_term
      pal_and_term #(.N_LIT(N_LIT)) term_i (
        .lits (lits),
        .mask (cfg[(BASE+k)*N_LIT +: N_LIT]),
        .en   (cfg[EN_BASE + BASE + k]),
        .term (prod[BASE+k])
      );
    end

    pal_or_group #(.N_T(NT)) or_i (
      .terms (prod[BASE +: NT]),
      .y     (out_vec[o])
    );

    always_comb begin
      if (!$isunknown({in_vec, cfg})) begin
        if (cfg[EN_BASE + BASE +: NT] == '0) begin
          assert_idle_group_low_R7: assert (out_vec[o] == 1'b0)
            else $error("output %0d high with its group disabled", o);
        end
        if (out_vec[o]) begin
          assert_group_owner_R6: assert (cfg[EN_BASE + BASE +: NT] != '0)
            else $error("output %0d high without an owned enabled term", o);
        end
      end
    end
  end

endmodule

// File: tb/pal_core_tb_top.sv
module pal_core_tb_top;

  localparam int N_TERM = 13;
  localparam int N_LIT  = 8;
  localparam int CFG_W  = N_TERM * (N_LIT + 1);
  localparam int EN_AT  = N_TERM * N_LIT;

  logic             clk;
  logic [3:0]       in_vec;
  logic [CFG_W-1:0] cfg;
  logic [4:0]       out_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pal_core dut_i (
    .in_vec  (in_vec),
    .cfg     (cfg),
    .out_vec (out_vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Directed vectors under the fixed configuration built in main:
  // {in_vec, expected out_vec}
  localparam logic [8:0] VEC [8] = '{
    {4'b0000, 5'b00101}, {4'b1011, 5'b10101}, {4'b1000, 5'b00100},
    {4'b1110, 5'b00110}, {4'b0110, 5'b00111}, {4'b1010, 5'b10100},
    {4'b1111, 5'b00111}, {4'b1001, 5'b00100}
  };

  // R6: owner output of each term
  function automatic int owner(input int t);
    if (t < 2)  return 0;
    if (t < 5)  return 1;
    if (t < 8)  return 2;
    if (t < 11) return 3;
    return 4;
  endfunction

  // Reference sum-of-products from R1..R7
  function automatic logic [4:0] model(input logic [CFG_W-1:0] c, input logic [3:0] x);
    logic [4:0] r;
    r = '0;
    for (int t = 0; t < N_TERM; t++) begin
      logic p;
      p = c[EN_AT + t];
      for (int l = 0; l < N_LIT; l++) begin
        logic lv;
        lv = (l % 2 == 0) ? x[l/2] : ~x[l/2];
        if (c[t*N_LIT + l] && !lv) p = 1'b0;
      end
      if (p) r[owner(t)] = 1'b1;
    end
    return r;
  endfunction

  task automatic set_term(input int t, input logic [7:0] m, input logic e);
    cfg[t*N_LIT +: N_LIT] = m;
    cfg[EN_AT + t] = e;
  endtask

  task automatic apply_check(input logic [3:0] x, input logic [4:0] exp, input string req);
    @(negedge clk);
    in_vec = x;
    #5;
    checks++;
    if (out_vec !== exp) begin
      errors++;
      $display("FAIL %s in=%b actual=%b expected=%b", req, x, out_vec, exp);
    end
  endtask

  initial begin
    in_vec = '0;
    cfg    = '0;
    // R8: all-zero configuration gives all outputs low
    apply_check(4'b0000, 5'b00000, "R8 zero cfg");
    apply_check(4'b1111, 5'b00000, "R8 zero cfg");

    // Directed configuration (R1 R2 R3 R4 R5)
    set_term(0,  8'b0000_0101, 1'b1); // in0 & in1
    set_term(1,  8'b1000_0000, 1'b1); // ~in3
    set_term(2,  8'b0000_0011, 1'b1); // in0 & ~in0 -> 0 (R4)
    set_term(3,  8'b0000_0000, 1'b0); // disabled empty term (R5)
    set_term(4,  8'b0001_0000, 1'b1); // in2
    set_term(5,  8'b0000_0000, 1'b1); // empty enabled -> 1 (R3)
    set_term(11, 8'b0010_0100, 1'b1); // in1 & ~in2
    set_term(12, 8'b1111_1111, 1'b0); // disabled (R5)
    for (int v = 0; v < 8; v++)
      apply_check(VEC[v][8:5], VEC[v][4:0], "R1 R2 R3 R4 R5 directed");

    // R6 R7: each single empty enabled term drives exactly its own output
    for (int t = 0; t < N_TERM; t++) begin
      cfg = '0;
      set_term(t, 8'h00, 1'b1);
      apply_check(4'b0101, 5'b00001 << owner(t), "R6 R7 term grouping");
    end

    // R3: every term enabled and empty -> all outputs high
    cfg = '0;
    for (int t = 0; t < N_TERM; t++) set_term(t, 8'h00, 1'b1);
    apply_check(4'b1010, 5'b11111, "R3 all empty terms");

    // R2 R7 R8: random configurations over all 16 inputs
    for (int s = 0; s < 6; s++) begin
      for (int t = 0; t < N_TERM; t++) begin
        logic [31:0] rv;
        rv = $urandom;
        // sparse masks so that terms are often true
        set_term(t, rv[7:0] & rv[15:8] & rv[23:16], rv[24] | rv[25]);
      end
      for (int x = 0; x < 16; x++)
        apply_check(4'(x), model(cfg, 4'(x)), "R2 R7 R8 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule